// File: doc/BRIEF.md
# Core Sleep and Wake Controller

This block decides when one processor core of a small cluster sits in a low-power wait and when it resumes. Decode hands it single-cycle pulses for three hint operations: wait-for-event, wait-for-interrupt and send-event. From these it drives a stall level that holds the pipeline while the core sleeps. When the core leaves sleep it gives a one-cycle wake pulse. A send-event produces a one-cycle event pulse that is broadcast to every core in the cluster.

Each core keeps a one-bit sticky event flag. An event that arrives while the core is running is stored in that flag, so a later wait-for-event sees it, clears the flag and carries on without stalling. The two wait kinds use different wake rules. Wait-for-event honours the interrupt and abort mask bits and the debug-enable flag, and it is also woken by events. Wait-for-interrupt is woken by IRQ and FIQ whatever their masks and by any debug-entry request, and it ignores events.

A parameter removes hint support. With it off, all three hints complete as no-operations.

Top module: `core_nap_ctrl`

## Requirements
- R1: A send-event pulse accepted while awake gives a one-cycle `evtOut` pulse on the next clock, and it also sets this core's own event flag.
- R2: A wait-for-event finds an event pending when the flag is set, or when an event (own send-event or a sibling bit) arrives in the same cycle. With an event pending it causes no stall, and the flag is left clear, so the next wait-for-event sleeps.
- R3: A wait-for-event with no event pending raises `coreStall` on the next clock. The stall holds until a wake condition is seen.
- R4: While sleeping in wait-for-event, IRQ wakes the core only if `maskI` is 0, and FIQ wakes it only if `maskF` is 0.
- R5: While sleeping in wait-for-event, an imprecise abort wakes the core only if `maskA` is 0, and a debug-entry request wakes it only if `dbgEn` is 1.
- R6: While sleeping in wait-for-event, any set bit of `sibEvt` wakes the core, except bit `CORE_ID`, which is always ignored.
- R7: While sleeping in wait-for-interrupt, IRQ and FIQ wake the core regardless of `maskI` and `maskF`, and `dbgReq` wakes it regardless of `dbgEn`. An abort wakes it only if `maskA` is 0. Events do not wake it, but they set the event flag.
- R8: On leaving sleep, `wakePulse` is 1 for exactly one cycle, and `coreStall` falls on that same clock. A wake out of wait-for-event leaves the event flag clear.
- R9: With `HINTS_ON` = 0, `coreStall`, `wakePulse` and `evtOut` stay 0 whatever the hint pulses are.
- R10: Reset (`rstN` low, asynchronous) puts the controller awake with the event flag clear and all outputs 0.
- R11: Hint pulses that arrive while the core sleeps are ignored: no `evtOut`, and no change of wait kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wfeReq | input | 1 | Wait-for-event pulse from decode |
| wfiReq | input | 1 | Wait-for-interrupt pulse from decode (wins over wfeReq) |
| sevReq | input | 1 | Send-event pulse from decode |
| irqLine | input | 1 | IRQ request level |
| fiqLine | input | 1 | FIQ request level |
| abortLine | input | 1 | Imprecise abort request level |
| maskI | input | 1 | IRQ mask bit, 1 = masked |
| maskF | input | 1 | FIQ mask bit, 1 = masked |
| maskA | input | 1 | Abort mask bit, 1 = masked |
| dbgReq | input | 1 | Debug-entry request |
| dbgEn | input | 1 | Debug enable flag |
| sibEvt | input | NUM_CORES | Event pulses from cluster cores, one bit per core |
| coreStall | output | 1 | Pipeline stall / sleep indication |
| wakePulse | output | 1 | One-cycle pulse when the core leaves sleep |
| evtOut | output | 1 | Event pulse broadcast to all cores |

## Verification
Every result is registered. A hint, wake source or event applied in one cycle therefore shows on `coreStall`, `wakePulse` or `evtOut` exactly one clock later, and a set event flag becomes visible at the following wait-for-event. The driver applies inputs at the falling edge and queues the values due after the next rising edge, tagged with that edge's number. The monitor samples 3 ns after each rising edge and compares only the entries due at that edge. A second instance with hint support off gets the same stimulus, and all of its outputs are expected to stay 0.

// File: rtl/nap_pkg.sv
package nap_pkg;

  typedef enum logic [1:0] {
    NAP_AWAKE = 2'd0,
    NAP_WFE   = 2'd1,
    NAP_WFI   = 2'd2
  } napState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrEvt;   // consume the event flag
    logic sendEvt;  // accepted send-event
  } napStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic evtPending; // flag set or event arriving now
    logic wakeWfe;    // wake condition under event-wait rules
    logic wakeWfi;    // wake condition under interrupt-wait rules
  } napStatus_t;

endpackage

// File: rtl/nap_datapath.sv
module nap_datapath
  import nap_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_ID   = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  napStrobe_t           strobe,
  input  logic [NUM_CORES-1:0] sibEvt,
  input  logic                 irqLine,
  input  logic                 fiqLine,
  input  logic                 abortLine,
  input  logic                 maskI,
  input  logic                 maskF,
  input  logic                 maskA,
  input  logic                 dbgReq,
  input  logic                 dbgEn,
  output napStatus_t           status,
  output logic                 evtOut
);

  logic [NUM_CORES-1:0] sibKept;
  logic                 evtIn;
  logic                 evtFlag;
  logic                 abortWake;

  // drop this core's own slot of the sibling vector
  for (genvar g = 0; g < NUM_CORES; g++) begin : g_sib
    if (g == CORE_ID) begin : g_own
      assign sibKept[g] = 1'b0;
    end else begin : g_other
      assign sibKept[g] = sibEvt[g];
    end
  end

  assign evtIn     = strobe.sendEvt | (|sibKept);
  assign abortWake = abortLine & ~maskA;

  always_comb begin
    status.evtPending = evtFlag | evtIn;
    status.wakeWfe    = (irqLine & ~maskI) | (fiqLine & ~maskF) | abortWake
                      | (dbgReq & dbgEn) | evtIn;
    status.wakeWfi    = irqLine | fiqLine | abortWake | dbgReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtFlag <= 1'b0;
      evtOut  <= 1'b0;
    end else begin
      evtOut <= strobe.sendEvt;
      if (strobe.clrEvt) begin
        evtFlag <= 1'b0;
      end else if (evtIn) begin
        evtFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nap_ctrl.sv
module nap_ctrl
  import nap_pkg::*;
#(
  parameter bit HINTS_ON = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wfeReq,
  input  logic       wfiReq,
  input  logic       sevReq,
  input  napStatus_t status,
  output napStrobe_t strobe,
  output logic       coreStall,
  output logic       wakePulse
);

  napState_t state, stateNxt;
  logic      awake;
  logic      doWfe, doWfi;
  logic      leaveWfe, leaveWfi;

  assign awake    = (state == NAP_AWAKE);
  assign doWfi    = HINTS_ON & awake & wfiReq;
  assign doWfe    = HINTS_ON & awake & wfeReq & ~wfiReq;
  assign leaveWfe = (state == NAP_WFE) & status.wakeWfe;
  assign leaveWfi = (state == NAP_WFI) & status.wakeWfi;

  always_comb begin
    strobe.sendEvt = HINTS_ON & awake & sevReq;
    strobe.clrEvt  = doWfe | leaveWfe;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      NAP_AWAKE: begin
        if (doWfi) begin
          stateNxt = NAP_WFI;
        end else if (doWfe && !status.evtPending) begin
          stateNxt = NAP_WFE;
        end
      end
      NAP_WFE: if (status.wakeWfe) stateNxt = NAP_AWAKE;
      NAP_WFI: if (status.wakeWfi) stateNxt = NAP_AWAKE;
      default: stateNxt = NAP_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= NAP_AWAKE;
      wakePulse <= 1'b0;
    end else begin
      state     <= stateNxt;
      wakePulse <= leaveWfe | leaveWfi;
    end
  end

  assign coreStall = ~awake;

endmodule

// File: rtl/core_nap_ctrl.sv
module core_nap_ctrl
  import nap_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_ID   = 0,
  parameter bit HINTS_ON  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wfeReq,
  input  logic                 wfiReq,
  input  logic                 sevReq,
  input  logic                 irqLine,
  input  logic                 fiqLine,
  input  logic                 abortLine,
  input  logic                 maskI,
  input  logic                 maskF,
  input  logic                 maskA,
  input  logic                 dbgReq,
  input  logic                 dbgEn,
  input  logic [NUM_CORES-1:0] sibEvt,
  output logic                 coreStall,
  output logic                 wakePulse,
  output logic                 evtOut
);

  napStrobe_t strobe;
  napStatus_t status;

  nap_ctrl #(.HINTS_ON(HINTS_ON)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wfeReq    (wfeReq),
    .wfiReq    (wfiReq),
    .sevReq    (sevReq),
    .status    (status),
    .strobe    (strobe),
    .coreStall (coreStall),
    .wakePulse (wakePulse)
  );

  nap_datapath #(.NUM_CORES(NUM_CORES), .CORE_ID(CORE_ID)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sibEvt    (sibEvt),
    .irqLine   (irqLine),
    .fiqLine   (fiqLine),
    .abortLine (abortLine),
    .maskI     (maskI),
    .maskF     (maskF),
    .maskA     (maskA),
    .dbgReq    (dbgReq),
    .dbgEn     (dbgEn),
    .status    (status),
    .evtOut    (evtOut)
  );

endmodule

// File: rtl/nap_checker.sv
module nap_checker #(
  parameter bit HINTS_ON = 1'b1
) (
  input logic clk,
  input logic rstN,
  input logic sevReq,
  input logic irqLine,
  input logic maskI,
  input logic coreStall,
  input logic wakePulse,
  input logic evtOut
);

  assert_wake_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  assert_wake_unstalls_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> !coreStall);

  assert_fall_has_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreStall) |-> wakePulse);

  assert_asleep_no_send_R11: assert property (@(posedge clk) disable iff (!rstN)
    coreStall |=> !evtOut);

  assert_irq_wakes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (coreStall && irqLine && !maskI) |=> !coreStall);

  if (HINTS_ON) begin : g_on
    assert_send_broadcast_R1: assert property (@(posedge clk) disable iff (!rstN)
      (sevReq && !coreStall) |=> evtOut);
  end else begin : g_off
    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
      !coreStall && !wakePulse && !evtOut);
  end

endmodule

bind core_nap_ctrl nap_checker #(.HINTS_ON(HINTS_ON)) uNapChk (
  .clk       (clk),
  .rstN      (rstN),
  .sevReq    (sevReq),
  .irqLine   (irqLine),
  .maskI     (maskI),
  .coreStall (coreStall),
  .wakePulse (wakePulse),
  .evtOut    (evtOut)
);

// File: tb/tb_core_nap_ctrl.sv
`timescale 1ns/1ps
module tb_core_nap_ctrl;

  localparam int NC  = 4;
  localparam int OWN = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wfeReq = 0, wfiReq = 0, sevReq = 0;
  logic irqLine = 0, fiqLine = 0, abortLine = 0;
  logic maskI = 0, maskF = 0, maskA = 0, dbgReq = 0, dbgEn = 0;
  logic [NC-1:0] sibEvt = '0;
  logic coreStall, wakePulse, evtOut;
  logic offStall, offWake, offEvt;

  // pending input values, applied by the driver at a falling edge
  logic pWfe = 0, pWfi = 0, pSev = 0;
  logic pIrq = 0, pFiq = 0, pAbort = 0;
  logic pMaskI = 0, pMaskF = 0, pMaskA = 0, pDbg = 0, pDbgEn = 0;
  logic [NC-1:0] pSib = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int    due;
    logic  s;
    logic  w;
    logic  e;
    string tag;
  } expItem_t;
  expItem_t q[$];

  always #5 clk = ~clk;

  core_nap_ctrl #(.NUM_CORES(NC), .CORE_ID(OWN), .HINTS_ON(1'b1)) dut (
    .clk(clk), .rstN(rstN), .wfeReq(wfeReq), .wfiReq(wfiReq), .sevReq(sevReq),
    .irqLine(irqLine), .fiqLine(fiqLine), .abortLine(abortLine),
    .maskI(maskI), .maskF(maskF), .maskA(maskA), .dbgReq(dbgReq), .dbgEn(dbgEn),
    .sibEvt(sibEvt), .coreStall(coreStall), .wakePulse(wakePulse), .evtOut(evtOut)
  );

  core_nap_ctrl #(.NUM_CORES(NC), .CORE_ID(OWN), .HINTS_ON(1'b0)) dutOff (
    .clk(clk), .rstN(rstN), .wfeReq(wfeReq), .wfiReq(wfiReq), .sevReq(sevReq),
    .irqLine(irqLine), .fiqLine(fiqLine), .abortLine(abortLine),
    .maskI(maskI), .maskF(maskF), .maskA(maskA), .dbgReq(dbgReq), .dbgEn(dbgEn),
    .sibEvt(sibEvt), .coreStall(offStall), .wakePulse(offWake), .evtOut(offEvt)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // driver: apply pending inputs, queue results due after the next rising edge
  task automatic step(input string tag, input logic s, input logic w, input logic e);
    expItem_t it;
    @(negedge clk);
    wfeReq = pWfe; wfiReq = pWfi; sevReq = pSev; sibEvt = pSib;
    irqLine = pIrq; fiqLine = pFiq; abortLine = pAbort;
    maskI = pMaskI; maskF = pMaskF; maskA = pMaskA; dbgReq = pDbg; dbgEn = pDbgEn;
    pWfe = 0; pWfi = 0; pSev = 0; pSib = '0;
    it.due = cyc + 1; it.s = s; it.w = w; it.e = e; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: sample 3 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (q.size() > 0 && q[0].due <= cyc) begin
        expItem_t it;
        it = q.pop_front();
        chk(it.tag, "coreStall", coreStall, it.s);
        chk(it.tag, "wakePulse", wakePulse, it.w);
        chk(it.tag, "evtOut", evtOut, it.e);
        chk({"R9 ", it.tag}, "off outputs", offStall | offWake | offEvt, 1'b0);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 in reset", "coreStall", coreStall, 1'b0);
    chk("R10 in reset", "wakePulse", wakePulse, 1'b0);
    chk("R10 in reset", "evtOut", evtOut, 1'b0);
    rstN = 1'b1;

    step("R10 idle after reset", 0, 0, 0);
    pWfe = 1; step("R3 wfe with flag clear sleeps", 1, 0, 0);
    step("R3 stall holds", 1, 0, 0);
    pMaskI = 1; pIrq = 1; step("R4 masked irq", 1, 0, 0);
    pIrq = 0; pMaskF = 1; pFiq = 1; step("R4 masked fiq", 1, 0, 0);
    pFiq = 0; pMaskA = 1; pAbort = 1; step("R5 masked abort", 1, 0, 0);
    pAbort = 0; pDbg = 1; pDbgEn = 0; step("R5 debug disabled", 1, 0, 0);
    pDbg = 0; pSib = 4'b0010; step("R6 own slot ignored", 1, 0, 0);
    pSib = 4'b1000; step("R6 sibling event wakes", 0, 1, 0);
    step("R8 pulse is single", 0, 0, 0);
    pWfe = 1; step("R8 flag clear after wake", 1, 0, 0);
    pMaskI = 0; pIrq = 1; step("R4 unmasked irq wakes", 0, 1, 0);
    pIrq = 0; pSib = 4'b0001; step("R2 event while awake", 0, 0, 0);
    pWfe = 1; step("R2 wfe returns at once", 0, 0, 0);
    pWfe = 1; step("R2 flag consumed", 1, 0, 0);
    pDbg = 1; pDbgEn = 1; step("R5 enabled debug wakes", 0, 1, 0);
    pDbg = 0; pDbgEn = 0; pSev = 1; step("R1 send-event broadcast", 0, 0, 1);
    step("R1 broadcast one cycle", 0, 0, 0);
    pWfe = 1; step("R1 own flag set", 0, 0, 0);
    pSev = 1; pWfe = 1; step("R2 send and wait same cycle", 0, 0, 1);
    pWfe = 1; step("R2 consumed after same cycle", 1, 0, 0);
    pMaskF = 0; pFiq = 1; step("R4 unmasked fiq wakes", 0, 1, 0);
    pFiq = 0; pMaskI = 1; pMaskF = 1; pWfi = 1; step("R7 wfi sleeps", 1, 0, 0);
    pSib = 4'b0100; step("R7 event does not wake wfi", 1, 0, 0);
    pAbort = 1; step("R7 masked abort", 1, 0, 0);
    pAbort = 0; pSev = 1; step("R11 send ignored asleep", 1, 0, 0);
    pWfe = 1; step("R11 wfe ignored asleep", 1, 0, 0);
    pDbg = 1; pDbgEn = 0; step("R7 debug wakes regardless", 0, 1, 0);
    pDbg = 0; pWfe = 1; step("R7 event kept through wfi", 0, 0, 0);
    pWfi = 1; step("R7 wfi sleeps again", 1, 0, 0);
    pIrq = 1; step("R7 irq ignores mask", 0, 1, 0);
    pIrq = 0; pWfi = 1; step("R7 wfi sleeps third", 1, 0, 0);
    pFiq = 1; step("R7 fiq ignores mask", 0, 1, 0);
    pFiq = 0; pWfi = 1; step("R7 wfi sleeps fourth", 1, 0, 0);
    pMaskA = 0; pAbort = 1; step("R7 unmasked abort wakes", 0, 1, 0);
    pAbort = 0; pWfe = 1; step("R5 wfe sleeps", 1, 0, 0);
    pAbort = 1; step("R5 unmasked abort wakes", 0, 1, 0);
    pAbort = 0;
    repeat (3) step("drain", 0, 0, 0);

    while (q.size() > 0) @(posedge clk);
    #4;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule